// File: doc/BRIEF.md
# Last-Writer Dependence Tracker

This block sits beside a directory and records which processors have consumed data produced by which others, so that checkpoint and rollback can be confined to the processors that actually communicated. Every cache line in the tracked range has an entry holding the identity of the processor that most recently took ownership of it. Each processor owns three pieces of state: a producer bitmap (whom it has read from), a consumer bitmap (who has read from it), and a small bit-vector write signature that summarises the lines it has written or fetched exclusively since its last checkpoint.

Coherence events arrive as a valid/ready stream of (kind, requester, line address). A shared or exclusive read compares the line's last writer against the reader and records a producer/consumer pair, but only when the last writer's signature still claims the address. This signature test lets a processor checkpoint by wiping only its own bitmaps and signature. The directory's last-writer entries are never swept. An entry left over from an earlier interval is recognised as stale because its writer's signature no longer matches. Ownership events then overwrite the entry and add the address to the requester's signature.

Back-pressure rules: an event transfers on a rising clock edge where `ev_valid` and `ev_ready` are both high. The source must hold the event steady while `ev_valid` is high and `ev_ready` is low. `ev_ready` is low in exactly those cycles in which any bit of `ckpt_clr` is high, and high in every other cycle. Bitmaps are registered and show the effect of an accepted event one edge after the transfer.

Top module: `lwdep_tracker`

## Requirements
- R1: After reset both bitmaps are all zero and no line has a last writer, so a read of a line that has never been owned records nothing.
- R2: A shared read (kind 0) by processor C of a line whose last writer is P, with P different from C and P's signature holding the address, sets bit P of C's producer row and bit C of P's consumer row. Row r occupies bits [r*NPROC +: NPROC] of `prod_map` and `cons_map`. Once set, a bit stays set until its row owner's checkpoint.
- R3: A read by the processor that is the line's current last writer records nothing. No processor ever appears in its own rows.
- R4: An ownership event (kind 1 write, kind 2 exclusive read, kind 3 treated as a write) makes the requester the line's last writer. It also sets signature bits hA and hB of the requester. For a 6-bit line address a, hA = (a ^ (a >> 4)) mod 16 and hB = ((a >> 2) ^ (a << 2)) mod 16.
- R5: An exclusive read first performs the same dependence check as a shared read, against the previous last writer, before taking ownership.
- R6: A checkpoint pulse on `ckpt_clr[p]` zeroes row p of both bitmaps and processor p's signature on the next edge. It leaves every last-writer entry and every other row unchanged.
- R7: A read of a line whose last writer has checkpointed since its write, and whose signature has not re-acquired both hashed bits, records no dependence.
- R8: While any `ckpt_clr` bit is high, `ev_ready` is low and the offered event is not taken. Once the clear has applied, the held event is taken and checked against the cleared state.
- R9: Signature aliasing may cause false positives: if a checkpointed last writer later owns a different line with the same hA and hB, a read of the old line records a dependence again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Coherence event offered |
| ev_ready | output | 1 | Event can be taken this cycle |
| ev_kind | input | 2 | 0 shared read, 1 write, 2 exclusive read, 3 write |
| ev_pid | input | PID_W (2) | Requesting processor |
| ev_addr | input | ADDR_W (6) | Line address |
| ckpt_clr | input | NPROC (4) | Per-processor checkpoint clear pulse |
| prod_map | output | NPROC*NPROC (16) | Producer rows, row r at [r*NPROC +: NPROC] |
| cons_map | output | NPROC*NPROC (16) | Consumer rows, same layout |

## Verification
Two things can land in the same cycle: a checkpoint clear of processor P and a read event whose dependence check consults P's signature. The bench raises `ckpt_clr` for the last writer of a line in the same cycle in which it offers a read of that line. It judges `ev_ready` low in that cycle and the bitmaps after the clear edge. It then confirms that the held read, taken one edge later, finds the writer stale and records nothing.

// File: rtl/lwdep_pkg.sv
package lwdep_pkg;
  localparam int NPROC  = 4;
  localparam int PID_W  = $clog2(NPROC);
  localparam int ADDR_W = 6;
  localparam int NLINES = 1 << ADDR_W;
  localparam int SIG_IW = 4;
  localparam int SIG_W  = 1 << SIG_IW;
  localparam int MAP_W  = NPROC * NPROC;

  typedef enum logic [1:0] {
    EV_RD_SH  = 2'd0,
    EV_WR     = 2'd1,
    EV_RD_EX  = 2'd2,
    EV_WR_ALT = 2'd3
  } ev_kind_e;

  function automatic logic [SIG_IW-1:0] hash_a(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] t;
    t = a ^ (a >> SIG_IW);
    return t[SIG_IW-1:0];
  endfunction

  function automatic logic [SIG_IW-1:0] hash_b(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] t;
    t = (a >> 2) ^ (a << 2);
    return t[SIG_IW-1:0];
  endfunction
endpackage

// File: rtl/lwdep_lw_table.sv
module lwdep_lw_table
  import lwdep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [PID_W-1:0]  rd_id,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PID_W-1:0]  wr_id
);
  logic [PID_W-1:0] owner_q [NLINES];
  logic [NLINES-1:0] known_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      known_q <= '0;
      for (int i = 0; i < NLINES; i++) owner_q[i] <= '0;
    end else if (wr_en) begin
      known_q[wr_addr] <= 1'b1;
      owner_q[wr_addr] <= wr_id;
    end
  end

  assign rd_valid = known_q[rd_addr];
  assign rd_id    = owner_q[rd_addr];
endmodule

// File: rtl/lwdep_sig_bank.sv
module lwdep_sig_bank
  import lwdep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPROC-1:0]  clr,
  input  logic              ins_en,
  input  logic [PID_W-1:0]  ins_pid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [PID_W-1:0]  q_pid,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              q_hit
);
  logic [SIG_W-1:0] sig_q [NPROC];
  logic [SIG_IW-1:0] ins_ha, ins_hb, q_ha, q_hb;

  assign ins_ha = hash_a(ins_addr);
  assign ins_hb = hash_b(ins_addr);
  assign q_ha   = hash_a(q_addr);
  assign q_hb   = hash_b(q_addr);

  for (genvar p = 0; p < NPROC; p++) begin : g_sig
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sig_q[p] <= '0;
      end else if (clr[p]) begin
        sig_q[p] <= '0;
      end else if (ins_en && (ins_pid == PID_W'(p))) begin
        sig_q[p][ins_ha] <= 1'b1;
        sig_q[p][ins_hb] <= 1'b1;
      end
    end
  end

  assign q_hit = sig_q[q_pid][q_ha] & sig_q[q_pid][q_hb];
endmodule

// File: rtl/lwdep_dep_maps.sv
module lwdep_dep_maps
  import lwdep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPROC-1:0] clr,
  input  logic             rec_en,
  input  logic [PID_W-1:0] rec_cons,
  input  logic [PID_W-1:0] rec_prod,
  output logic [MAP_W-1:0] prod_flat,
  output logic [MAP_W-1:0] cons_flat
);
  for (genvar r = 0; r < NPROC; r++) begin : g_row
    logic [NPROC-1:0] prod_row_q, cons_row_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prod_row_q <= '0;
        cons_row_q <= '0;
      end else if (clr[r]) begin
        prod_row_q <= '0;
        cons_row_q <= '0;
      end else if (rec_en) begin
        if (rec_cons == PID_W'(r)) prod_row_q[rec_prod] <= 1'b1;
        if (rec_prod == PID_W'(r)) cons_row_q[rec_cons] <= 1'b1;
      end
    end

    assign prod_flat[r*NPROC +: NPROC] = prod_row_q;
    assign cons_flat[r*NPROC +: NPROC] = cons_row_q;
  end
endmodule

// File: rtl/lwdep_tracker.sv
module lwdep_tracker
  import lwdep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [1:0]        ev_kind,
  input  logic [PID_W-1:0]  ev_pid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [NPROC-1:0]  ckpt_clr,
  output logic [MAP_W-1:0]  prod_map,
  output logic [MAP_W-1:0]  cons_map
);
  logic             take;
  logic             is_read, is_own;
  logic             owner_known, sig_hit, record;
  logic [PID_W-1:0] owner_id;
  ev_kind_e         kind;

  assign kind     = ev_kind_e'(ev_kind);
  assign ev_ready = ~|ckpt_clr;
  assign take     = ev_valid & ev_ready;
  assign is_read  = (kind == EV_RD_SH) || (kind == EV_RD_EX);
  assign is_own   = (kind != EV_RD_SH);
  assign record   = take & is_read & owner_known & (owner_id != ev_pid) & sig_hit;

  lwdep_lw_table u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_addr  (ev_addr),
    .rd_valid (owner_known),
    .rd_id    (owner_id),
    .wr_en    (take & is_own),
    .wr_addr  (ev_addr),
    .wr_id    (ev_pid)
  );

  lwdep_sig_bank u_sig (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ckpt_clr),
    .ins_en   (take & is_own),
    .ins_pid  (ev_pid),
    .ins_addr (ev_addr),
    .q_pid    (owner_id),
    .q_addr   (ev_addr),
    .q_hit    (sig_hit)
  );

  lwdep_dep_maps u_maps (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ckpt_clr),
    .rec_en    (record),
    .rec_cons  (ev_pid),
    .rec_prod  (owner_id),
    .prod_flat (prod_map),
    .cons_flat (cons_map)
  );
endmodule

// File: rtl/lwdep_chk.sv
module lwdep_chk
  import lwdep_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [1:0]        ev_kind,
  input logic [PID_W-1:0]  ev_pid,
  input logic [ADDR_W-1:0] ev_addr,
  input logic [NPROC-1:0]  ckpt_clr,
  input logic [MAP_W-1:0]  prod_map,
  input logic [MAP_W-1:0]  cons_map
);
  AST_STALL_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|ckpt_clr) |-> !ev_ready); // R8

  AST_NO_NEW_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ready |=> ((prod_map & ~$past(prod_map)) == '0)); // R8

  for (genvar r = 0; r < NPROC; r++) begin : g_row_chk
    AST_CLEAR_EMPTIES_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      ckpt_clr[r] |=> (prod_map[r*NPROC +: NPROC] == '0) && (cons_map[r*NPROC +: NPROC] == '0)); // R6

    AST_ROW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !ckpt_clr[r] |=> ((prod_map[r*NPROC +: NPROC] & $past(prod_map[r*NPROC +: NPROC]))
                        == $past(prod_map[r*NPROC +: NPROC]))); // R2

    AST_NO_SELF_DEP: assert property (@(posedge clk) disable iff (!rst_n)
      !prod_map[r*NPROC + r] && !cons_map[r*NPROC + r]); // R3

    for (genvar p = 0; p < NPROC; p++) begin : g_pair
      AST_PAIR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prod_map[r*NPROC + p]) |-> cons_map[p*NPROC + r]); // R2
    end
  end
endmodule

bind lwdep_tracker lwdep_chk u_chk (.*);

// File: tb/sim_lwdep_tracker.sv
module sim_lwdep_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  typedef struct {
    logic [15:0] p;
    logic [15:0] c;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [1:0]  ev_kind = 2'd0;
  logic [1:0]  ev_pid = 2'd0;
  logic [5:0]  ev_addr = 6'd0;
  logic [3:0]  ckpt_clr = 4'd0;
  logic [15:0] prod_map, cons_map;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  exp_t e;

  int          m_lw [64];
  bit          m_lwv [64];
  logic [15:0] m_sig [NP];
  logic [15:0] m_prod = '0;
  logic [15:0] m_cons = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lwdep_tracker u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_pid(ev_pid), .ev_addr(ev_addr),
    .ckpt_clr(ckpt_clr), .prod_map(prod_map), .cons_map(cons_map)
  );

  function automatic int ha(input int a);
    return (a ^ (a >> 4)) & 15;
  endfunction
  function automatic int hb(input int a);
    return ((a >> 2) ^ (a << 2)) & 15;
  endfunction

  task automatic m_event(input int kind, input int pid, input int addr);
    int w;
    if ((kind == 0 || kind == 2) && m_lwv[addr]) begin
      w = m_lw[addr];
      if (w != pid && m_sig[w][ha(addr)] && m_sig[w][hb(addr)]) begin
        m_prod[pid*NP + w] = 1'b1;
        m_cons[w*NP + pid] = 1'b1;
      end
    end
    if (kind != 0) begin
      m_lw[addr]  = pid;
      m_lwv[addr] = 1'b1;
      m_sig[pid][ha(addr)] = 1'b1;
      m_sig[pid][hb(addr)] = 1'b1;
    end
  endtask

  task automatic m_clear(input logic [3:0] mask);
    for (int r = 0; r < NP; r++) if (mask[r]) begin
      m_prod[r*NP +: NP] = '0;
      m_cons[r*NP +: NP] = '0;
      m_sig[r] = '0;
    end
  endtask

  task automatic push(input string tag);
    exp_t x;
    x.p = m_prod; x.c = m_cons; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic ev(input int kind, input int pid, input int addr, input string tag);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = 2'(kind); ev_pid = 2'(pid); ev_addr = 6'(addr);
    @(posedge clk); #1;
    ev_valid = 1'b0;
    m_event(kind, pid, addr);
    push(tag);
  endtask

  task automatic clr(input logic [3:0] mask, input string tag);
    @(negedge clk);
    ckpt_clr = mask;
    @(posedge clk); #1;
    ckpt_clr = '0;
    m_clear(mask);
    push(tag);
  endtask

  task automatic clr_with_ev(input logic [3:0] mask, input int kind, input int pid,
                             input int addr, input string tag);
    @(negedge clk);
    ckpt_clr = mask;
    ev_valid = 1'b1; ev_kind = 2'(kind); ev_pid = 2'(pid); ev_addr = 6'(addr);
    #1;
    checks++;
    if (ev_ready !== 1'b0) begin
      errors++;
      $display("FAIL %s ev_ready during clear: got %b expected 0", tag, ev_ready);
    end
    @(posedge clk); #1;
    ckpt_clr = '0;
    m_clear(mask);
    push({tag, " clear edge"});
    @(posedge clk); #1;
    ev_valid = 1'b0;
    m_event(kind, pid, addr);
    push({tag, " held event"});
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (prod_map !== e.p || cons_map !== e.c) begin
        errors++;
        $display("FAIL %s: prod=%h cons=%h expected prod=%h cons=%h",
                 e.tag, prod_map, cons_map, e.p, e.c);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_lw[i] = 0; m_lwv[i] = 1'b0; end
    for (int i = 0; i < NP; i++) m_sig[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (prod_map !== 16'h0 || cons_map !== 16'h0 || ev_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: prod=%h cons=%h ready=%b expected 0 0 1",
               prod_map, cons_map, ev_ready);
    end
    @(negedge clk); rst_n = 1'b1;

    ev(0, 0, 9,  "R1 read of never-owned line");
    ev(1, 1, 5,  "R4 write by P1 line 5");
    ev(0, 2, 5,  "R2 P2 reads from P1");
    ev(0, 1, 5,  "R3 last writer rereads");
    ev(2, 3, 5,  "R5 P3 exclusive read checks P1");
    ev(0, 0, 5,  "R4 ownership moved to P3");
    ev(0, 2, 5,  "R2 repeated read keeps bits");
    ev(3, 2, 20, "R4 kind3 write by P2 line 20");
    clr(4'b0100, "R6 clear P2 rows only");
    ev(0, 0, 20, "R7 stale writer P2 line 20");
    clr(4'b1000, "R6 clear P3");
    ev(1, 3, 20, "R6 P3 owns alias of line 5");
    ev(0, 2, 5,  "R6 line 5 writer kept as P3");
    clr_with_ev(4'b1000, 0, 1, 5, "R8 clear P3 with read of line 5");
    ev(1, 1, 17, "R9 P1 writes line 17");
    clr(4'b0010, "R9 clear P1");
    ev(1, 1, 0,  "R9 P1 writes alias line 0");
    ev(0, 2, 17, "R9 false positive recorded");
    ev(0, 3, 9,  "R1 line 9 still unowned");

    wait (q.size() == 0);
    @(negedge clk); #1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule